// File: doc/BRIEF.md
# Load/store port byte memory

This block is a small byte-addressed data memory behind a single load/store request port. A requester waits for `busy_o` to be low, then presents either a store or a load request together with an access size and an address, qualified by `addr_vld_i`. The block takes the address and answers with `addr_ack_o`. For a store, the requester then pulses `st_strobe_i` for one cycle with the data in the low bytes of `st_data_i`. The block writes only the byte lanes that the size and the low address bits select. For a load, the block reads the addressed word, moves the addressed bytes down to bit 0 with the upper bits zeroed, and shows the result for one cycle with `ld_vld_o`.

Byte order is little-endian. The lowest address lands in bits 7:0 of a 64-bit word. Requests are assumed to be naturally aligned. Address bits above the array size are ignored, so the array repeats through the address space.

The controller has five states:
- `S_IDLE`: free.
- `S_ST_WAIT`: address taken, waiting for the store strobe.
- `S_LD_FETCH`: address taken, read in progress.
- `S_LD_SHOW`: load data valid.
- `S_RELEASE`: waiting for the requester to drop `addr_vld_i`.

The transitions are:
- Request accept: `S_IDLE` to `S_ST_WAIT` on a store, or `S_IDLE` to `S_LD_FETCH` on a load.
- Strobe consume: `S_ST_WAIT` to `S_RELEASE`.
- Fetch: `S_LD_FETCH` to `S_LD_SHOW`.
- Deliver: `S_LD_SHOW` to `S_RELEASE`.
- Free: `S_RELEASE` to `S_IDLE` once `addr_vld_i` is low.

Top module: `lsu_mem_port`

## Requirements
- R1: Immediately after reset, `busy_o`, `addr_ack_o` and `ld_vld_o` are all low.
- R2: In idle, a request is accepted at a clock edge where `addr_vld_i` is high and at least one of `st_req_i` and `ld_req_i` is high. If both are high, the request is a store. From the next cycle, `addr_ack_o` and `busy_o` are high. With `addr_vld_i` low, or with both indicators low, nothing is accepted and `busy_o` stays low.
- R3: While a store waits, a high `st_strobe_i` at a clock edge writes the low N bytes of `st_data_i` to addresses A..A+N-1. A strobe at any other time has no effect on memory contents.
- R4: A store leaves every byte outside its N addressed bytes unchanged.
- R5: For a load, `ld_vld_o` is high in the second cycle after the accepting edge, and for exactly one cycle.
- R6: Load data is right-justified: the byte at A is in bits 7:0, and all bits at or above 8*N are zero.
- R7: Byte order is little-endian. After a 2-byte store of 0xBEEF to 0x4 and a 2-byte store of 0xF00F to 0x6, a 4-byte load from 0x4 returns 0xF00FBEEF.
- R8: `busy_o` is high in every state other than idle. `addr_ack_o` is high from the cycle after acceptance until the strobe is consumed or the load data has been shown, and is low in the release state.
- R9: After a store or a load completes, the block stays busy, with `addr_ack_o` low, for as long as `addr_vld_i` stays high. It is idle in the cycle after the first edge that sees `addr_vld_i` low.
- R10: Only address bits below log2(MEM_BYTES) select a byte. Higher address bits are ignored.
- R11: `size_i` encodes N as follows: 0 means 1 byte, 1 means 2, 2 means 4, 3 means 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_req_i | input | 1 | Store request indicator |
| ld_req_i | input | 1 | Load request indicator |
| size_i | input | 2 | Access size code (1/2/4/8 bytes) |
| addr_i | input | ADDR_W (48) | Byte address |
| addr_vld_i | input | 1 | Address valid |
| addr_ack_o | output | 1 | Address accepted |
| st_strobe_i | input | 1 | One-cycle store data strobe |
| st_data_i | input | DATA_W (64) | Store data, right-justified |
| ld_vld_o | output | 1 | Load data valid |
| ld_data_o | output | DATA_W (64) | Load data, right-justified |
| busy_o | output | 1 | Request in progress |

## Verification
The bench builds the block with its default parameters: a 48-bit address, a 64-bit data path and a 256-byte array. The array therefore holds 32 words of eight lanes each. Every size code, every lane offset inside a word, and address bits above bit 7 (which exercise aliasing) are all within reach. A behavioural byte-array model follows each request and compares busy, acknowledge, load-valid and load data on every clock.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_ST_WAIT  = 3'd1,
        S_LD_FETCH = 3'd2,
        S_LD_SHOW  = 3'd3,
        S_RELEASE  = 3'd4
    } lsm_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } lsm_size_e;

endpackage

// File: rtl/lsm_lane_mask.sv
module lsm_lane_mask #(
    parameter int MASK_W = 8,
    parameter int OFF_W  = 3
) (
    input  logic [1:0]        size,
    input  logic [OFF_W-1:0]  offset,
    output logic [MASK_W-1:0] mask
);
    logic [MASK_W-1:0]   base;
    logic [2*MASK_W-1:0] wide;

    always_comb begin
        base = '0;
        for (int b = 0; b < MASK_W; b++) begin
            if (b < (1 << size)) base[b] = 1'b1;
        end
        wide = {{MASK_W{1'b0}}, base} << offset;
        mask = wide[MASK_W-1:0];
    end
endmodule

// File: rtl/lsm_byte_lane.sv
module lsm_byte_lane #(
    parameter int DEPTH = 32,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[idx] <= wdata;
    end

    assign rdata = cells[idx];
endmodule

// File: rtl/lsm_load_align.sv
module lsm_load_align #(
    parameter int DATA_W = 64,
    parameter int OFF_W  = 3
) (
    input  logic [DATA_W-1:0] raw,
    input  logic [1:0]        size,
    input  logic [OFF_W-1:0]  offset,
    output logic [DATA_W-1:0] justified
);
    logic [DATA_W-1:0] shifted;

    always_comb begin
        shifted = raw >> {offset, 3'b000};
        for (int b = 0; b < DATA_W; b++) begin
            justified[b] = (b < (8 << size)) ? shifted[b] : 1'b0;
        end
    end
endmodule

// File: rtl/lsu_mem_port.sv
module lsu_mem_port
    import lsm_pkg::*;
#(
    parameter int ADDR_W    = 48,
    parameter int DATA_W    = 64,
    parameter int MEM_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_req_i,
    input  logic              ld_req_i,
    input  logic [1:0]        size_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              addr_vld_i,
    output logic              addr_ack_o,
    input  logic              st_strobe_i,
    input  logic [DATA_W-1:0] st_data_i,
    output logic              ld_vld_o,
    output logic [DATA_W-1:0] ld_data_o,
    output logic              busy_o
);
    localparam int MASK_W = DATA_W / 8;
    localparam int OFF_W  = $clog2(MASK_W);
    localparam int WORDS  = MEM_BYTES / MASK_W;
    localparam int IDX_W  = $clog2(WORDS);

    lsm_state_e        state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [OFF_W-1:0]  off_q;
    logic [1:0]        size_q;
    logic [DATA_W-1:0] ld_data_q;

    logic              start;
    logic [MASK_W-1:0] lane_mask;
    logic [DATA_W-1:0] st_placed;
    logic [DATA_W-1:0] raw_word;
    logic [DATA_W-1:0] justified;

    assign start     = addr_vld_i & (st_req_i | ld_req_i);
    assign st_placed = st_data_i << {off_q, 3'b000};

    lsm_lane_mask #(.MASK_W(MASK_W), .OFF_W(OFF_W)) u_mask (
        .size   (size_q),
        .offset (off_q),
        .mask   (lane_mask)
    );

    for (genvar g = 0; g < MASK_W; g++) begin : g_lane
        lsm_byte_lane #(.DEPTH(WORDS), .IDX_W(IDX_W)) u_lane (
            .clk   (clk),
            .we    ((state_q == S_ST_WAIT) && st_strobe_i && lane_mask[g]),
            .idx   (idx_q),
            .wdata (st_placed[8*g +: 8]),
            .rdata (raw_word[8*g +: 8])
        );
    end

    lsm_load_align #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_align (
        .raw       (raw_word),
        .size      (size_q),
        .offset    (off_q),
        .justified (justified)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (start) state_d = st_req_i ? S_ST_WAIT : S_LD_FETCH;
            S_ST_WAIT:  if (st_strobe_i) state_d = S_RELEASE;
            S_LD_FETCH: state_d = S_LD_SHOW;
            S_LD_SHOW:  state_d = S_RELEASE;
            S_RELEASE:  if (!addr_vld_i) state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // state and request registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            idx_q     <= '0;
            off_q     <= '0;
            size_q    <= 2'd0;
            ld_data_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && start) begin
                idx_q  <= IDX_W'((addr_i >> OFF_W) % WORDS);
                off_q  <= addr_i[OFF_W-1:0];
                size_q <= size_i;
            end
            if (state_q == S_LD_FETCH) ld_data_q <= justified;
        end
    end

    // outputs
    always_comb begin
        busy_o     = 1'b1;
        addr_ack_o = 1'b0;
        ld_vld_o   = 1'b0;
        unique case (state_q)
            S_IDLE:     busy_o = 1'b0;
            S_ST_WAIT:  addr_ack_o = 1'b1;
            S_LD_FETCH: addr_ack_o = 1'b1;
            S_LD_SHOW: begin
                addr_ack_o = 1'b1;
                ld_vld_o   = 1'b1;
            end
            S_RELEASE:  busy_o = 1'b1;
            default:    busy_o = 1'b1;
        endcase
    end

    assign ld_data_o = ld_data_q;

    assert_ack_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ack_o |-> busy_o);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!addr_ack_o && !ld_vld_o));
    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start) |=> (addr_ack_o && busy_o));
    assert_ldvld_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_vld_o |=> !ld_vld_o);
    assert_ldvld_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ld_vld_o) |-> $past(addr_ack_o));
    assert_hold_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RELEASE && addr_vld_i) |=> (busy_o && !addr_ack_o));
    assert_mask_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ST_WAIT && ((off_q & OFF_W'((1 << size_q) - 1)) == '0))
            |-> ($countones(lane_mask) == (1 << size_q)));
endmodule

// File: tb/sim_lsu_mem_port.sv
module sim_lsu_mem_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_req_i = 1'b0;
    logic        ld_req_i = 1'b0;
    logic [1:0]  size_i = 2'd0;
    logic [47:0] addr_i = '0;
    logic        addr_vld_i = 1'b0;
    logic        addr_ack_o;
    logic        st_strobe_i = 1'b0;
    logic [63:0] st_data_i = '0;
    logic        ld_vld_o;
    logic [63:0] ld_data_o;
    logic        busy_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lsu_mem_port u0 (
        .clk(clk), .rst_n(rst_n), .st_req_i(st_req_i), .ld_req_i(ld_req_i),
        .size_i(size_i), .addr_i(addr_i), .addr_vld_i(addr_vld_i),
        .addr_ack_o(addr_ack_o), .st_strobe_i(st_strobe_i), .st_data_i(st_data_i),
        .ld_vld_o(ld_vld_o), .ld_data_o(ld_data_o), .busy_o(busy_o)
    );

    // behavioural reference: byte array plus request phase
    logic [7:0]  mem_m [256];
    int          ph;
    int          m_addr;
    int          m_n;
    logic [63:0] m_ld;

    initial for (int i = 0; i < 256; i++) mem_m[i] = 8'h00;

    always @(posedge clk) begin
        if (!rst_n) begin
            ph <= 0;
        end else begin
            case (ph)
                0: if (addr_vld_i && (st_req_i || ld_req_i)) begin
                    ph     <= st_req_i ? 1 : 2;
                    m_addr <= int'(addr_i[7:0]);
                    m_n    <= 1 << size_i;
                end
                1: if (st_strobe_i) begin
                    for (int i = 0; i < m_n; i++)
                        mem_m[(m_addr + i) % 256] <= st_data_i[8*i +: 8];
                    ph <= 4;
                end
                2: begin
                    logic [63:0] t;
                    t = '0;
                    for (int i = 0; i < m_n; i++) t[8*i +: 8] = mem_m[(m_addr + i) % 256];
                    m_ld <= t;
                    ph   <= 3;
                end
                3: ph <= 4;
                default: if (!addr_vld_i) ph <= 0;
            endcase
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // cycle-by-cycle comparison (R8, R5)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R8 busy", {63'd0, busy_o}, {63'd0, ph != 0});
            check("R8 ack", {63'd0, addr_ack_o}, {63'd0, ph >= 1 && ph <= 3});
            check("R5 ld_vld", {63'd0, ld_vld_o}, {63'd0, ph == 3});
            if (ph == 3) check("R6 ld_data", ld_data_o, m_ld);
        end
    end

    task automatic do_store(input logic [47:0] a, input logic [1:0] sz, input logic [63:0] d);
        while (busy_o) @(negedge clk);
        st_req_i = 1'b1; size_i = sz; addr_i = a; addr_vld_i = 1'b1;
        @(negedge clk);
        while (!addr_ack_o) @(negedge clk);
        st_data_i = d; st_strobe_i = 1'b1;
        @(negedge clk);
        st_strobe_i = 1'b0; st_req_i = 1'b0; addr_vld_i = 1'b0;
        st_data_i = 64'hDEAD_DEAD_DEAD_DEAD;
    endtask

    task automatic do_load(input logic [47:0] a, input logic [1:0] sz, output logic [63:0] d);
        while (busy_o) @(negedge clk);
        ld_req_i = 1'b1; size_i = sz; addr_i = a; addr_vld_i = 1'b1;
        @(negedge clk);
        while (!ld_vld_o) @(negedge clk);
        d = ld_data_o;
        ld_req_i = 1'b0; addr_vld_i = 1'b0;
        @(negedge clk);
        check("R5 ld_vld single cycle", {63'd0, ld_vld_o}, 64'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", {63'd0, busy_o}, 64'd0);
        check("R1 ack", {63'd0, addr_ack_o}, 64'd0);
        check("R1 ld_vld", {63'd0, ld_vld_o}, 64'd0);

        // R7 little-endian halfwords, R11 size codes
        do_store(48'h4, 2'd1, 64'hBEEF);
        do_store(48'h6, 2'd1, 64'hF00F);
        do_load(48'h4, 2'd1, r); check("R7 half at 4", r, 64'hBEEF);
        do_load(48'h6, 2'd1, r); check("R7 half at 6", r, 64'hF00F);
        do_load(48'h4, 2'd2, r); check("R7 word at 4", r, 64'hF00FBEEF);

        // R4 lanes outside the mask untouched, R3 byte store
        do_store(48'h10, 2'd3, 64'h1122334455667788);
        do_store(48'h13, 2'd0, 64'h55AA);
        do_load(48'h10, 2'd3, r); check("R4 dword after byte store", r, 64'h11223344AA667788);

        // R6 right-justified zero upper bits
        do_load(48'h17, 2'd0, r); check("R6 top byte", r, 64'h11);
        do_load(48'h14, 2'd1, r); check("R6 half at 0x14", r, 64'h3344);

        // R3 only low N bytes of store data used
        do_store(48'h20, 2'd3, 64'h0);
        do_store(48'h22, 2'd1, 64'hFFFF_FFFF_FFFF_1234);
        do_load(48'h20, 2'd3, r); check("R3 low bytes only", r, 64'h0000_0000_1234_0000);

        // R10 upper address bits ignored
        do_store(48'h1_0000_0040, 2'd2, 64'hCAFEF00D);
        do_load(48'h40, 2'd2, r); check("R10 alias", r, 64'hCAFEF00D);

        // R2 no accept without addr_vld or without an indicator
        ld_req_i = 1'b1; addr_i = 48'h10; size_i = 2'd3;
        repeat (3) begin
            @(negedge clk);
            check("R2 no addr_vld", {63'd0, busy_o}, 64'd0);
        end
        ld_req_i = 1'b0; addr_vld_i = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check("R2 no indicator", {63'd0, busy_o}, 64'd0);
        end
        addr_vld_i = 1'b0;

        // R3 stray strobe while idle has no effect
        st_data_i = 64'hFFFF_FFFF_FFFF_FFFF; st_strobe_i = 1'b1;
        @(negedge clk);
        st_strobe_i = 1'b0;
        do_load(48'h10, 2'd3, r); check("R3 stray strobe ignored", r, 64'h11223344AA667788);

        // R2 both indicators means store
        while (busy_o) @(negedge clk);
        st_req_i = 1'b1; ld_req_i = 1'b1; size_i = 2'd0; addr_i = 48'h30; addr_vld_i = 1'b1;
        @(negedge clk);
        st_data_i = 64'h5A; st_strobe_i = 1'b1;
        @(negedge clk);
        check("R2 both means store, no ld_vld", {63'd0, ld_vld_o}, 64'd0);
        st_strobe_i = 1'b0; st_req_i = 1'b0; ld_req_i = 1'b0; addr_vld_i = 1'b0;
        do_load(48'h30, 2'd0, r); check("R2 both stored", r, 64'h5A);

        // R9 release held while addr_vld stays high
        while (busy_o) @(negedge clk);
        ld_req_i = 1'b1; size_i = 2'd0; addr_i = 48'h30; addr_vld_i = 1'b1;
        @(negedge clk);
        while (!ld_vld_o) @(negedge clk);
        repeat (3) begin
            @(negedge clk);
            check("R9 busy held", {63'd0, busy_o}, 64'd1);
            check("R9 ack low", {63'd0, addr_ack_o}, 64'd0);
        end
        ld_req_i = 1'b0; addr_vld_i = 1'b0;
        @(negedge clk);
        check("R9 idle after drop", {63'd0, busy_o}, 64'd0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule